// File: doc/BRIEF.md
# Pulse Accumulator with Event and Gated Modes

The block counts activity on a single external input. In event mode, every active edge of the input advances a 16-bit counter. In gated mode, the input acts as an enable: the counter advances once per prescaler tick while the input sits at its active level. One configuration bit picks the polarity. With that bit low, event mode counts rising edges and the gate is active-high. With it high, event mode counts falling edges and the gate is active-low. The input passes through a two-flop synchronizer before any edge is detected.

Two sticky flags record activity. The wrap flag is raised when the counter rolls from all ones to zero. The input flag is raised on a counted edge in event mode, or on the trailing edge of the gate in gated mode. Software clears a flag by writing a one to its bit. When the fast-clear control is on, any read or write of the counter clears both flags. Registers are reached through a combinational-read, single-cycle strobe bus. The bus supports byte accesses, and a word access that moves all 16 counter bits in one cycle. A byte read of the high half saves the low half, so that a read of the high byte followed by a read of the low byte is consistent.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the flag register, the word count and the low count byte all read as zero.
- R2: In event mode, each active edge on the input (rising when polarity is 0, falling when it is 1) advances the count by exactly one.
- R3: In event mode, an active edge sets the input flag (flag register bit 0).
- R4: In gated mode, the count advances by one on each cycle in which the tick is high and the synchronized input is at its active level (high for polarity 0, low for polarity 1). Otherwise the count holds.
- R5: In gated mode, the input flag is set when the gate goes from active to inactive, and not when it becomes active.
- R6: An increment from 0xFFFF wraps the count to 0x0000 and sets the wrap flag (flag register bit 1).
- R7: Writing the flag register (address 0) with bit 1 set clears the wrap flag, and with bit 0 set clears the input flag. A zero in a bit leaves that flag unchanged.
- R8: With fast-clear on, a read or write at a count address (2 or 3) clears both flags. With fast-clear off, such accesses leave the flags unchanged. Reading the flag register never clears flags.
- R9: The flag register reads as {14 zero bits, wrap flag, input flag}.
- R10: A word access at address 2 reads or writes all 16 count bits in one cycle. A byte access at address 2 covers count bits 15:8, and a byte access at address 3 covers bits 7:0. Byte data sits in bus bits 7:0, and bits 15:8 read as zero.
- R11: A byte read at address 2 saves count bits 7:0. The next byte read at address 3 returns the saved value. Later byte reads at address 3 return the live count.
- R12: When a hardware set and a software clear hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick for gated accumulation |
| pin_in | input | 1 | Asynchronous pulse/gate input |
| gated_mode | input | 1 | 0 = event counting, 1 = gated accumulation |
| active_low | input | 1 | Polarity: 0 = rising edge / high gate, 1 = falling edge / low gate |
| fast_clr_en | input | 1 | Enables flag clearing on count accesses |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| word_acc | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr | input | 2 | Register address: 0 flags, 2 count high / word, 3 count low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle. They also assume that mode, polarity and fast-clear settings change only while the block is idle, so that a switch cannot create an edge that is counted or flagged. The bench reconfigures only with the tick low and the input at its idle level. It then waits for the synchronizer to settle and clears the flags and the count before any stimulus. Every input pulse lasts several cycles, so each edge crosses the synchronizer cleanly. The one deliberate overlap, a hardware set against a software clear, is placed on the exact cycle the edge reaches the flag.

// File: rtl/pulse_accum.sv
module pulse_accum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        pin_in,
  input  logic        gated_mode,
  input  logic        active_low,
  input  logic        fast_clr_en,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        word_acc,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_LO   = 2'd3;

  logic        s1, s2, prev;
  logic [15:0] cnt_q;
  logic [7:0]  shadow;
  logic        shv, ovf_q, pif_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, prev} <= 3'b000;
    else        {s1, s2, prev} <= {pin_in, s1, s2};

  wire rise       = s2 & ~prev;
  wire fall       = ~s2 & prev;
  wire gate_on    = active_low ? ~s2 : s2;
  wire lead_edge  = active_low ? fall : rise;
  wire trail_edge = active_low ? rise : fall;

  wire inc     = gated_mode ? (tick & gate_on) : lead_edge;
  wire pif_set = gated_mode ? trail_edge : lead_edge;

  wire cnt_sel = (addr == A_HI) | (addr == A_LO);
  wire cnt_wr  = wr_en & cnt_sel;
  wire cnt_acc = (rd_en | wr_en) & cnt_sel;
  wire hi_rd   = rd_en & ~word_acc & (addr == A_HI);
  wire lo_rd   = rd_en & ~word_acc & (addr == A_LO);
  wire flag_wr = wr_en & (addr == A_FLAG);
  wire fclr    = fast_clr_en & cnt_acc;

  wire ovf_set = inc & ~cnt_wr & (cnt_q == 16'hFFFF);
  wire ovf_clr = fclr | (flag_wr & wdata[1]);
  wire pif_clr = fclr | (flag_wr & wdata[0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (cnt_wr) begin
      if (addr == A_HI && word_acc) cnt_q <= wdata;
      else if (addr == A_HI)        cnt_q[15:8] <= wdata[7:0];
      else                          cnt_q[7:0]  <= wdata[7:0];
    end
    else if (inc) cnt_q <= cnt_q + 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_q <= 1'b0;
      pif_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
      pif_q <= pif_set | (pif_q & ~pif_clr);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shadow <= '0;
      shv    <= 1'b0;
    end else if (hi_rd) begin
      shadow <= cnt_q[7:0];
      shv    <= 1'b1;
    end else if (lo_rd | cnt_wr) begin
      shv    <= 1'b0;
    end

  always_comb begin
    case (addr)
      A_FLAG:  rdata = {14'd0, ovf_q, pif_q};
      A_HI:    rdata = word_acc ? cnt_q : {8'd0, cnt_q[15:8]};
      A_LO:    rdata = {8'd0, shv ? shadow : cnt_q[7:0]};
      default: rdata = '0;
    endcase
  end

  // R6
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_wr && cnt_q == 16'hFFFF) |=> (cnt_q == 16'd0 && ovf_q));

  // R12
  pif_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pif_set |=> pif_q);

  // R7
  ovf_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLAG && wdata[1] && !ovf_set) |=> !ovf_q);

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !(tick && gate_on) && !cnt_wr) |=> $stable(cnt_q));

  // R8
  fast_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr_en && cnt_acc && !ovf_set && !pif_set) |=> (!ovf_q && !pif_q));

  // R11
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (shv && shadow == $past(cnt_q[7:0])));
endmodule

// File: tb/pulse_accum_test.sv
module pulse_accum_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, pin_in = 0;
  logic gated_mode = 0, active_low = 0, fast_clr_en = 0;
  logic rd_en = 0, wr_en = 0, word_acc = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pulse_accum uut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(logic [1:0] a, logic w, logic [15:0] d);
    @(negedge clk); addr = a; word_acc = w; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic br(logic [1:0] a, logic w, output logic [15:0] d);
    @(negedge clk); addr = a; word_acc = w; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic gm, logic al, logic fc);
    @(negedge clk);
    tick = 0; pin_in = al; gated_mode = gm; active_low = al; fast_clr_en = fc;
    settle(5);
    bw(2'd0, 0, 16'h0003);
    bw(2'd2, 1, 16'h0000);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin_in = ~active_low;
      settle(3);
      pin_in = active_low;
      settle(3);
    end
    settle(3);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    settle(3);
    rst_n = 1;
    settle(2);
    br(2'd0, 0, d); chk("R1 flags", d, 16'h0000);
    br(2'd2, 1, d); chk("R1 count", d, 16'h0000);
    br(2'd3, 0, d); chk("R1 low", d, 16'h0000);

    for (int al = 0; al < 2; al++)
      for (int n = 0; n < 6; n++) begin
        cfg(0, al[0], 0);
        pulses(n);
        br(2'd2, 1, d); chk("R2 event count", d, 16'(n));
        br(2'd0, 0, d); chk("R3/R9 event flag", d, (n > 0) ? 16'h0001 : 16'h0000);
      end

    for (int al = 0; al < 2; al++) begin
      cfg(1, al[0], 0);
      @(negedge clk); pin_in = ~al[0];
      settle(5);
      br(2'd2, 1, d); chk("R4 hold without tick", d, 16'h0000);
      br(2'd0, 0, d); chk("R5 no flag on leading edge", d, 16'h0000);
      pin_in = al[0];
      settle(5);
      br(2'd0, 0, d); chk("R5 flag on trailing edge", d, 16'h0001);
      for (int len = 1; len < 7; len++) begin
        cfg(1, al[0], 0);
        @(negedge clk); tick = 1; pin_in = ~al[0];
        settle(len);
        pin_in = al[0];
        settle(5);
        tick = 0;
        br(2'd2, 1, d); chk("R4 gated count", d, 16'(len));
        br(2'd0, 0, d); chk("R5 gated flag", d, 16'h0001);
      end
    end

    cfg(0, 0, 0);
    bw(2'd2, 1, 16'hFFFE);
    pulses(1);
    br(2'd2, 1, d); chk("R6 before wrap", d, 16'hFFFF);
    br(2'd0, 0, d); chk("R6 no wrap flag yet", d, 16'h0001);
    pulses(1);
    br(2'd2, 1, d); chk("R6 wrapped count", d, 16'h0000);
    br(2'd0, 0, d); chk("R6/R9 both flags", d, 16'h0003);
    bw(2'd0, 0, 16'h0000);
    br(2'd0, 0, d); chk("R7 write zero keeps", d, 16'h0003);
    bw(2'd0, 0, 16'h0001);
    br(2'd0, 0, d); chk("R7 clear input flag", d, 16'h0002);
    bw(2'd0, 0, 16'h0002);
    br(2'd0, 0, d); chk("R7 clear wrap flag", d, 16'h0000);

    cfg(0, 0, 0);
    pulses(1);
    br(2'd2, 0, d);
    br(2'd0, 0, d); chk("R8 fast-clear off", d, 16'h0001);
    fast_clr_en = 1;
    br(2'd0, 0, d); chk("R8 flag read no clear", d, 16'h0001);
    br(2'd3, 0, d);
    br(2'd0, 0, d); chk("R8 clear on count read", d, 16'h0000);
    pulses(1);
    bw(2'd3, 0, 16'h0055);
    br(2'd0, 0, d); chk("R8 clear on count write", d, 16'h0000);
    fast_clr_en = 0;

    bw(2'd2, 1, 16'hA5C3);
    br(2'd2, 1, d); chk("R10 word read", d, 16'hA5C3);
    br(2'd2, 0, d); chk("R10 high byte read", d, 16'h00A5);
    bw(2'd2, 0, 16'h007E);
    br(2'd2, 1, d); chk("R10 high byte write", d, 16'h7EC3);
    bw(2'd3, 0, 16'h0011);
    br(2'd2, 1, d); chk("R10 low byte write", d, 16'h7E11);

    bw(2'd2, 1, 16'h12FF);
    br(2'd2, 0, d); chk("R11 high byte", d, 16'h0012);
    pulses(1);
    br(2'd3, 0, d); chk("R11 shadowed low", d, 16'h00FF);
    br(2'd3, 0, d); chk("R11 live low", d, 16'h0000);
    br(2'd2, 1, d); chk("R11 live word", d, 16'h1300);

    cfg(0, 0, 0);
    @(negedge clk); pin_in = 1;
    @(negedge clk);
    bw(2'd0, 0, 16'h0001);
    br(2'd0, 0, d); chk("R12 set wins over clear", d, 16'h0001);
    pin_in = 0;
    settle(4);
    bw(2'd0, 0, 16'h0001);
    br(2'd0, 0, d); chk("R12 later clear works", d, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule